// File: doc/BRIEF.md
# Programmable Duty-Cycle Clock Divider

This block turns a fast source clock into a slower output clock. Two run-time counts set the output period and duty cycle: a high count and a low count, both in source cycles. A pass-through control sends the source clock straight to the output. A half-cycle control moves the output's falling edge half a source cycle earlier, onto a falling edge of the source. With it, odd divide factors can reach a 50% duty cycle.

Software or a sequencer writes new settings through a one-cycle write strobe. The settings go into a shadow copy. They become active only at the start of the next output period, so a change never cuts a pulse short. A synchronous active-high reset holds the output low and restores the default settings. The output period restarts with its high phase on the first source edge after reset is released.

Top module: `duty_clk_div`

## Requirements
- R1: With pass-through off, each output period begins on a source rising edge. The output is high for H source cycles and then low for L source cycles, where H and L are the active high and low counts. The period is H+L source cycles.
- R2: The high and low counts are CNT_W bits wide (8 by default). With pass-through off and half-cycle off, counts 5/5 give divide by 10 at 50% duty. Counts 4/6 give 4 cycles high and 6 cycles low. Counts 255/255 give divide by 510.
- R3: While the active pass-through bit is 1, the output equals the source clock: high in the first half of every source cycle and low in the second half.
- R4: While the active half-cycle bit is 0, the output's high-to-low transition happens on a source rising edge.
- R5: While the active half-cycle bit is 1, the high time is H-0.5 cycles and the low time is L+0.5 cycles, with the high-to-low transition on a source falling edge. Counts 2/1 give divide by 3 with 1.5 cycles high and 1.5 cycles low.
- R6: A write (cfg_we high at a rising edge) captures all four settings. They become active at the next period-start edge after the write edge. A write on a period-start edge itself waits for the following period.
- R7: A written high or low count of 0 acts as a count of 1.
- R8: While rst is high at a rising edge, the output is low from that edge on. Reset restores the defaults: H=DEF_HI, L=DEF_LO, pass-through off, half-cycle off. The first rising edge with rst low starts a new period in its high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Fast source clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the settings below |
| cfg_hi | input | CNT_W | High-phase length in source cycles |
| cfg_lo | input | CNT_W | Low-phase length in source cycles |
| cfg_bypass | input | 1 | 1: output follows the source clock |
| cfg_odd | input | 1 | 1: falling edge of output moved half a cycle earlier |
| clk_out | output | 1 | Divided clock |

## Verification
The output is sampled twice in every source cycle, once in the high half and once in the low half. This separates rising-edge transitions from falling-edge ones.

Directed runs cover the following:
- Equal counts, which expose errors in the period length.
- Unequal counts, which expose swapped high and low phases.
- Odd factors with the half-cycle bit both set and clear, which show whether the fall lands on the right edge.
- Zero counts and the largest counts, which test the clamp and the counter width.
- Pass-through.

Writes are placed both in the middle of a long period and exactly on a period-start edge, to pin down when new settings take over. Seeded random runs then mix short counts, mode bits and write timing, and compare every half-cycle against a reference model of the period.

// File: rtl/duty_clk_div_pkg.sv
package duty_clk_div_pkg;
  // Mode flags that travel with the counts through shadow and active stages.
  typedef struct packed {
    logic bypass;
    logic odd;
  } div_flags_t;
endpackage

// File: rtl/duty_clk_div_cfg.sv
module duty_clk_div_cfg
  import duty_clk_div_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned DEF_HI = 1,
  parameter int unsigned DEF_LO = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_hi,
  input  logic [CNT_W-1:0] wr_lo,
  input  div_flags_t       wr_flags,
  input  logic             period_start,
  output logic [CNT_W-1:0] act_hi,
  output logic [CNT_W-1:0] act_lo,
  output div_flags_t       act_flags
);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
  localparam logic [CNT_W-1:0] RST_H = (DEF_HI == 0) ? ONE : CNT_W'(DEF_HI);
  localparam logic [CNT_W-1:0] RST_L = (DEF_LO == 0) ? ONE : CNT_W'(DEF_LO);

  logic [CNT_W-1:0] sh_hi, sh_lo;
  div_flags_t       sh_flags;

  // Shadow stage: zero counts are clamped on capture.
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_hi    <= RST_H;
      sh_lo    <= RST_L;
      sh_flags <= '0;
    end else if (wr_en) begin
      sh_hi    <= (wr_hi == '0) ? ONE : wr_hi;
      sh_lo    <= (wr_lo == '0) ? ONE : wr_lo;
      sh_flags <= wr_flags;
    end
  end

  // Active stage: only moves on a period boundary.
  always_ff @(posedge clk) begin
    if (rst) begin
      act_hi    <= RST_H;
      act_lo    <= RST_L;
      act_flags <= '0;
    end else if (period_start) begin
      act_hi    <= sh_hi;
      act_lo    <= sh_lo;
      act_flags <= sh_flags;
    end
  end
endmodule

// File: rtl/duty_clk_div_count.sv
module duty_clk_div_count #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] act_hi,
  input  logic [CNT_W-1:0] act_lo,
  output logic             period_start,
  output logic             hi_q,
  output logic             last_hi,
  output logic [CNT_W:0]   phase_cnt
);
  localparam int unsigned PW = CNT_W + 1;

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] cnt_inc;
  logic [PW-1:0] last_idx;
  logic          restart_q;

  assign cnt_inc      = cnt_q + PW'(1);
  assign last_idx     = {1'b0, act_hi} + {1'b0, act_lo} - PW'(1);
  assign period_start = restart_q | (cnt_q == last_idx);
  assign last_hi      = hi_q & (cnt_q == ({1'b0, act_hi} - PW'(1)));
  assign phase_cnt    = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      restart_q <= 1'b1;
      hi_q      <= 1'b0;
    end else if (period_start) begin
      cnt_q     <= '0;
      restart_q <= 1'b0;
      hi_q      <= 1'b1;
    end else begin
      cnt_q <= cnt_inc;
      hi_q  <= (cnt_inc < {1'b0, act_hi});
    end
  end
endmodule

// File: rtl/duty_clk_div_half.sv
module duty_clk_div_half (
  input  logic clk,
  input  logic rst,
  input  logic last_hi,
  output logic kill_q
);
  // Falling-edge stage: marks the middle of the last high cycle.
  always_ff @(negedge clk) begin
    if (rst) kill_q <= 1'b0;
    else     kill_q <= last_hi;
  end
endmodule

// File: rtl/duty_clk_div.sv
module duty_clk_div
  import duty_clk_div_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned DEF_HI = 1,
  parameter int unsigned DEF_LO = 1
) (
  input  logic             clk_src,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CNT_W-1:0] cfg_hi,
  input  logic [CNT_W-1:0] cfg_lo,
  input  logic             cfg_bypass,
  input  logic             cfg_odd,
  output logic             clk_out
);
  logic [CNT_W-1:0] act_hi, act_lo;
  div_flags_t       act_flags;
  div_flags_t       wr_flags;
  logic             period_start, hi_q, last_hi, kill_q;
  logic [CNT_W:0]   phase_cnt;

  assign wr_flags = '{bypass: cfg_bypass, odd: cfg_odd};

  duty_clk_div_cfg #(.CNT_W(CNT_W), .DEF_HI(DEF_HI), .DEF_LO(DEF_LO)) u_cfg (
    .clk(clk_src), .rst(rst), .wr_en(cfg_we), .wr_hi(cfg_hi), .wr_lo(cfg_lo),
    .wr_flags(wr_flags), .period_start(period_start),
    .act_hi(act_hi), .act_lo(act_lo), .act_flags(act_flags)
  );

  duty_clk_div_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk_src), .rst(rst), .act_hi(act_hi), .act_lo(act_lo),
    .period_start(period_start), .hi_q(hi_q), .last_hi(last_hi),
    .phase_cnt(phase_cnt)
  );

  duty_clk_div_half u_half (
    .clk(clk_src), .rst(rst), .last_hi(last_hi), .kill_q(kill_q)
  );

  // Output select: both inputs come straight from flops or the source.
  assign clk_out = act_flags.bypass ? clk_src : (hi_q & ~(act_flags.odd & kill_q));
endmodule

// File: rtl/duty_clk_div_chk.sv
module duty_clk_div_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             hi_q,
  input logic [CNT_W:0]   phase_cnt,
  input logic [CNT_W-1:0] act_hi,
  input logic [CNT_W-1:0] act_lo,
  input logic [1:0]       act_flags,
  input logic             clk_out
);
  logic rst_seen = 1'b0;
  always_ff @(posedge clk) rst_seen <= rst;

  // R1: every period opens with the output high
  p_hi_start_r1: assert property (@(posedge clk) disable iff (rst) start |=> hi_q);

  // R6: active settings change only on a period-start edge
  p_cfg_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !start |=> ($stable(act_hi) && $stable(act_lo) && $stable(act_flags)));

  // R7: active counts are never zero
  p_no_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (act_hi != '0) && (act_lo != '0));

  // R1: phase counter stays inside the period
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
    phase_cnt <= ({1'b0, act_hi} + {1'b0, act_lo} - 1'b1));

  // R8: output low after a reset edge
  always @(negedge clk) begin
    if (rst_seen) a_rst_low_r8: assert (clk_out == 1'b0);
  end
endmodule

bind duty_clk_div duty_clk_div_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk_src), .rst(rst), .start(period_start), .hi_q(hi_q),
  .phase_cnt(phase_cnt), .act_hi(act_hi), .act_lo(act_lo),
  .act_flags(act_flags), .clk_out(clk_out)
);

// File: tb/duty_clk_div_tb.sv
module duty_clk_div_tb;
  localparam int CNT_W  = 8;
  localparam int DEF_HI = 1;
  localparam int DEF_LO = 1;

  logic clk_src = 1'b0;
  logic rst = 1'b1, cfg_we = 1'b0, cfg_bypass = 1'b0, cfg_odd = 1'b0;
  logic [CNT_W-1:0] cfg_hi = '0, cfg_lo = '0;
  logic clk_out;

  int n_run = 0, n_fail = 0, cyc_no = 0;
  string tag = "R8";
  bit done = 0;

  // reference model state
  int  sh_h, sh_l, a_h, a_l, m_c;
  bit  sh_b, sh_o, a_b, a_o, m_restart;

  always #2 clk_src = ~clk_src;   // 250 MHz

  duty_clk_div #(.CNT_W(CNT_W), .DEF_HI(DEF_HI), .DEF_LO(DEF_LO)) u_dut (
    .clk_src(clk_src), .rst(rst), .cfg_we(cfg_we), .cfg_hi(cfg_hi),
    .cfg_lo(cfg_lo), .cfg_bypass(cfg_bypass), .cfg_odd(cfg_odd),
    .clk_out(clk_out)
  );

  function automatic int clamp1(int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic bit exp_half(bit second);
    if (a_b) return !second;
    if (m_c >= a_h) return 1'b0;
    if (second && a_o && (m_c == a_h - 1)) return 1'b0;
    return 1'b1;
  endfunction

  task automatic model_edge();
    bit start;
    if (rst) begin
      sh_h = clamp1(DEF_HI); sh_l = clamp1(DEF_LO); sh_b = 0; sh_o = 0;
      a_h = sh_h; a_l = sh_l; a_b = 0; a_o = 0; m_c = 0; m_restart = 1;
      return;
    end
    start = m_restart || (m_c == a_h + a_l - 1);
    if (start) begin
      a_h = sh_h; a_l = sh_l; a_b = sh_b; a_o = sh_o; m_c = 0;
    end else m_c++;
    m_restart = 0;
    if (cfg_we) begin
      sh_h = clamp1(int'(cfg_hi)); sh_l = clamp1(int'(cfg_lo));
      sh_b = cfg_bypass; sh_o = cfg_odd;
    end
  endtask

  task automatic check(bit exp, bit second);
    n_run++;
    if (clk_out !== exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d half %0d: clk_out=%0b expected %0b",
               tag, cyc_no, second, clk_out, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_src);
    model_edge();
    cyc_no++;
    #1 check(rst ? 1'b0 : exp_half(1'b0), 1'b0);
    @(negedge clk_src);
    #1 check(rst ? 1'b0 : exp_half(1'b1), 1'b1);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(int h, int l, bit b, bit o);
    cfg_we = 1; cfg_hi = CNT_W'(h); cfg_lo = CNT_W'(l); cfg_bypass = b; cfg_odd = o;
    cyc();
    cfg_we = 0;
  endtask

  // wait until the model says the next edge starts a period
  task automatic align_start();
    while (!(m_c == a_h + a_l - 1)) cyc();
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    tag = "R8"; rst = 1; run(4);           // output low in reset
    rst = 0; run(8);                        // defaults: 1/1
    tag = "R2"; wr(5, 5, 0, 0); run(40);
    wr(4, 6, 0, 0); run(40);
    tag = "R4"; wr(3, 2, 0, 0); run(30);
    tag = "R5"; wr(2, 1, 0, 1); run(30);
    wr(4, 3, 0, 1); run(30);
    wr(1, 1, 0, 1); run(12);
    tag = "R3"; wr(3, 3, 1, 0); run(20);
    wr(2, 5, 0, 0); run(20);
    tag = "R7"; wr(0, 0, 0, 0); run(16);
    wr(0, 3, 0, 1); run(16);
    tag = "R6"; wr(8, 8, 0, 0); run(20);
    run(3); wr(2, 2, 0, 0); run(30);        // write mid-period
    align_start(); wr(6, 1, 0, 0); run(30); // write on period-start edge
    tag = "R2"; wr(255, 255, 0, 0); run(1100);
    tag = "R8"; rst = 1; run(3); rst = 0; run(10);
    tag = "R1";
    for (int i = 0; i < 30000; i++) begin
      if ($urandom % 25 == 0)
        wr($urandom % 17, $urandom % 17, ($urandom % 6) == 0, ($urandom % 3) == 0);
      else cyc();
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule